// File: doc/BRIEF.md
# Hysteretic Window Control Sequencer

This block runs bang-bang current regulation around a single comparator. The comparator's reference input is switched between a programmable low limit and a programmable high limit, so one comparator covers both edges of a window. The block watches the synchronized comparator level for one edge direction at a time. When that edge arrives, the block accepts a trip and does four things on the same clock: it commands the PWM stage on or off, switches the reference to the other limit, reverses the edge direction it watches for, and reloads a blanking counter.

A falling-edge trip at the low limit stops the PWM stage. A rising-edge trip at the high limit starts it. While the blanking counter runs, comparator edges are ignored. This keeps switching noise and filter ripple from causing false trips. While the block is enabled, it tells the reference filter to stay in its transition setting. The analog comparator, the reference filter and the PWM generator sit outside the block.

Top module: `hwc_top`

## Requirements
- R1: A falling comparator edge (level 1 in the previous cycle, 0 now), seen while enabled, unblanked and watching for falling edges, is accepted as a trip. From the next clock, `pwm_on` is 0.
- R2: A rising comparator edge (0 then 1), seen while enabled, unblanked and watching for rising edges, is accepted as a trip. From the next clock, `pwm_on` is 1.
- R3: On the clock that accepts a trip, the watched edge direction reverses. The same clock moves `dac_code` to the other limit: `lim_low` after a rising trip, `lim_high` after a falling trip.
- R4: Every accepted trip loads the blanking counter with `blank_len`. `blank_busy` then stays high for exactly `blank_len` cycles. During those cycles, comparator edges change neither `pwm_on` nor `dac_code`.
- R5: A `blank_len` of 0 disables blanking. `blank_busy` stays low, and an opposite edge in the very next cycle is accepted.
- R6: `dac_code` is driven combinationally from the live value of the selected limit. `lim_high` and `lim_low` are independent 12-bit inputs.
- R7: `filt_mode` is 2'b10 (transition) in every cycle after a cycle with `enable` high. It is 2'b00 (slow) after a cycle with `enable` low.
- R8: The first enabled clock after `enable` was low sets `pwm_on` to 1, selects `lim_high`, watches for rising edges and loads the blanking counter. No trip is accepted on that clock.
- R9: A clock with `enable` low sets `pwm_on` to 0, clears blanking, selects `lim_high` with rising-edge watch, and accepts no trips.
- R10: During reset, `pwm_on` is 0, `blank_busy` is 0, `filt_mode` is 2'b00 and `dac_code` equals `lim_high`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Runs the hysteretic sequence while high |
| cmp_level | input | 1 | Comparator output, already synchronized to clk |
| lim_high | input | 12 | Upper window limit code |
| lim_low | input | 12 | Lower window limit code |
| blank_len | input | 16 | Blanking length in clocks; 0 disables blanking |
| dac_code | output | 12 | Reference code presented to the comparator |
| pwm_on | output | 1 | PWM run command (1 = run, 0 = stop) |
| filt_mode | output | 2 | Reference filter setting: 2'b10 transition, 2'b00 slow |
| blank_busy | output | 1 | High while the blanking counter is nonzero |

## Verification
The assertions assume three things about the inputs. `cmp_level` is free of metastability and changes only between clock edges. `enable` is low whenever reset is released. `blank_len` holds steady from the clock that arms blanking until the cycle after it, so its past value describes the loaded count. The stimulus changes all inputs just after the falling clock edge. It holds `enable` low through reset and changes `blank_len` only on idle cycles. Within those rules it toggles the comparator both inside and outside blanking windows, and it drops and restores `enable` at random points in the sequence.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  localparam int unsigned DAC_W   = 12;
  localparam int unsigned BLANK_W = 16;

  typedef enum logic [1:0] {
    FILT_SLOW  = 2'b00,
    FILT_FAST  = 2'b01,
    FILT_TRANS = 2'b10
  } filt_mode_e;
endpackage

// File: rtl/hwc_edge_det.sv
module hwc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    lvl_d = lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/hwc_blank_tmr.sv
module hwc_blank_tmr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clear_i) begin
      cnt_d  = ZERO;
      cnt_en = 1'b1;
    end else if (load_i) begin
      cnt_d  = len_i;
      cnt_en = 1'b1;
    end else if (cnt_q != ZERO) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != ZERO);
endmodule

// File: rtl/hwc_window_fsm.sv
module hwc_window_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic busy_i,
  output logic active_o,
  output logic watch_rise_o,
  output logic pwm_on_o,
  output logic load_o,
  output logic clear_o
);
  logic active_q, active_d;
  logic watch_q,  watch_d;
  logic pwm_q,    pwm_d;
  logic start;
  logic trip;

  always_comb begin
    start = enable_i & ~active_q;
    trip  = enable_i & active_q & ~busy_i &
            (watch_q ? rise_i : fall_i);

    active_d = enable_i;
    watch_d  = watch_q;
    pwm_d    = pwm_q;
    if (!enable_i) begin
      watch_d = 1'b1;
      pwm_d   = 1'b0;
    end else if (start) begin
      watch_d = 1'b1;
      pwm_d   = 1'b1;
    end else if (trip) begin
      watch_d = ~watch_q;
      pwm_d   = watch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      watch_q  <= 1'b1;
      pwm_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      watch_q  <= watch_d;
      pwm_q    <= pwm_d;
    end
  end

  assign active_o     = active_q;
  assign watch_rise_o = watch_q;
  assign pwm_on_o     = pwm_q;
  assign load_o       = start | trip;
  assign clear_o      = ~enable_i;
endmodule

// File: rtl/hwc_top.sv
module hwc_top
  import hwc_pkg::*;
#(
  parameter int unsigned DW = DAC_W,
  parameter int unsigned BW = BLANK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cmp_level,
  input  logic [DW-1:0] lim_high,
  input  logic [DW-1:0] lim_low,
  input  logic [BW-1:0] blank_len,
  output logic [DW-1:0] dac_code,
  output logic          pwm_on,
  output logic [1:0]    filt_mode,
  output logic          blank_busy
);
  logic rise, fall;
  logic active, watch_rise, load, clear;

  hwc_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (cmp_level),
    .rise_o (rise),
    .fall_o (fall)
  );

  hwc_window_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable_i     (enable),
    .rise_i       (rise),
    .fall_i       (fall),
    .busy_i       (blank_busy),
    .active_o     (active),
    .watch_rise_o (watch_rise),
    .pwm_on_o     (pwm_on),
    .load_o       (load),
    .clear_o      (clear)
  );

  hwc_blank_tmr #(.CNT_W(BW)) u_blank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .clear_i (clear),
    .len_i   (blank_len),
    .busy_o  (blank_busy)
  );

  filt_mode_e filt_sel;

  always_comb begin
    dac_code = watch_rise ? lim_high : lim_low;
    filt_sel = active ? FILT_TRANS : FILT_SLOW;
  end

  assign filt_mode = filt_sel;
endmodule

// File: rtl/hwc_chk.sv
module hwc_chk #(
  parameter int unsigned DW = 12,
  parameter int unsigned BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic [DW-1:0] lim_high,
  input logic [BW-1:0] blank_len,
  input logic [DW-1:0] dac_code,
  input logic          pwm_on,
  input logic [1:0]    filt_mode,
  input logic          blank_busy
);
  // R9
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!pwm_on && !blank_busy && dac_code == lim_high));

  // R8
  start_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (pwm_on && dac_code == lim_high &&
                       blank_busy == ($past(blank_len) != '0)));

  // R7
  filt_trans_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (filt_mode == 2'b10));

  // R7
  filt_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (filt_mode == 2'b00));

  // R3
  stop_selects_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_on) |-> (dac_code == lim_high));

  // R4
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_busy && enable) |=> $stable(pwm_on));
endmodule

bind hwc_top hwc_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .lim_high   (lim_high),
  .blank_len  (blank_len),
  .dac_code   (dac_code),
  .pwm_on     (pwm_on),
  .filt_mode  (filt_mode),
  .blank_busy (blank_busy)
);

// File: tb/hwc_top_tb.sv
module hwc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cmp_level = 1'b0;
  logic [11:0] lim_high = 12'd2481;
  logic [11:0] lim_low  = 12'd1241;
  logic [15:0] blank_len = 16'd4;
  logic [11:0] dac_code;
  logic        pwm_on;
  logic [1:0]  filt_mode;
  logic        blank_busy;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  int m_en = 0, m_prev = 0, m_rise = 1, m_pwm = 0, m_cnt = 0;
  int m_evt = 0; // 0 none, 1 rising trip, 2 falling trip, 3 start, 4 disabled

  always #(CLK_PERIOD/2) clk = ~clk;

  hwc_top u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_level(cmp_level),
    .lim_high(lim_high), .lim_low(lim_low), .blank_len(blank_len),
    .dac_code(dac_code), .pwm_on(pwm_on), .filt_mode(filt_mode),
    .blank_busy(blank_busy)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_prev = 0; m_rise = 1; m_pwm = 0; m_cnt = 0; m_evt = 0;
    end else begin
      int lvl;
      bit trip;
      lvl = int'(cmp_level);
      m_evt = 0;
      if (!enable) begin
        m_en = 0; m_rise = 1; m_pwm = 0; m_cnt = 0; m_evt = 4;
      end else if (m_en == 0) begin
        m_en = 1; m_rise = 1; m_pwm = 1; m_cnt = int'(blank_len); m_evt = 3;
      end else begin
        trip = (m_cnt == 0) &&
               (m_rise != 0 ? (m_prev == 0 && lvl == 1) : (m_prev == 1 && lvl == 0));
        if (trip) begin
          m_evt = (m_rise != 0) ? 1 : 2;
          m_pwm = m_rise;
          m_rise = (m_rise != 0) ? 0 : 1;
          m_cnt = int'(blank_len);
        end else if (m_cnt > 0) begin
          m_cnt = m_cnt - 1;
        end
      end
      m_prev = lvl;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R10", "pwm_on", int'(pwm_on), 0);
        chk("R10", "blank_busy", int'(blank_busy), 0);
        chk("R10", "filt_mode", int'(filt_mode), 0);
        chk("R10", "dac_code", int'(dac_code), int'(lim_high));
      end else begin
        string pt, dt, bt;
        case (m_evt)
          1: pt = "R2";
          2: pt = "R1";
          3: pt = "R8";
          4: pt = "R9";
          default: pt = "R4";
        endcase
        dt = (m_evt == 1 || m_evt == 2) ? "R3" : "R6";
        bt = (blank_len == 16'd0) ? "R5" : "R4";
        chk(pt, "pwm_on", int'(pwm_on), m_pwm);
        chk(dt, "dac_code", int'(dac_code),
            (m_rise != 0) ? int'(lim_high) : int'(lim_low));
        chk(bt, "blank_busy", int'(blank_busy), (m_cnt != 0) ? 1 : 0);
        chk("R7", "filt_mode", int'(filt_mode), (m_en != 0) ? 2 : 0);
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    // R8: start with blanking of 4; early rising edge ignored (R4)
    enable = 1'b1;
    step(1);
    cmp_level = 1'b1;
    step(2);
    cmp_level = 1'b0;
    step(6);
    // R2: rising trip after blanking
    cmp_level = 1'b1;
    step(1);
    // R6: move limits while low limit is selected
    lim_low = 12'd205;
    step(6);
    // R1: falling trip
    cmp_level = 1'b0;
    step(6);
    lim_high = 12'd3890;
    step(2);
    // R5: no blanking, back-to-back trips
    blank_len = 16'd0;
    step(2);
    cmp_level = 1'b1;
    step(1);
    cmp_level = 1'b0;
    step(1);
    cmp_level = 1'b1;
    step(2);
    // R9: disable with edges present
    enable = 1'b0;
    cmp_level = 1'b0;
    step(1);
    cmp_level = 1'b1;
    step(3);
    blank_len = 16'd3;
    step(1);
    enable = 1'b1;
    step(4);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 35) cmp_level = ~cmp_level;
      if (r == 50) enable = ~enable;
      if (r == 60) lim_high = 12'($urandom_range(2048, 4095));
      if (r == 61) lim_low  = 12'($urandom_range(0, 2047));
      if (r == 70 && !blank_busy && !enable) blank_len = 16'($urandom_range(0, 6));
      if (r > 90 && !enable) enable = 1'b1;
      step(1);
    end
    step(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule